// File: doc/BRIEF.md
# Dual-Port Audio Interrupt and Reset Controller

This block gathers event requests from two audio ports, each with a transmit (output) direction and a receive (input) direction. Each request sets a sticky pending bit. The pending bits pass through two independent enable registers, and the result drives one interrupt line to the CPU. Software reads the pending register to find which direction needs service. It clears sources by writing zeros to their positions.

The same register window holds a software reset register and a clock enable register. The reset register has a global reset, an interrupt-logic reset and one reset per port. All four are active low: a stored 0 holds that function in reset and a stored 1 releases it. The clock enable register turns each port's clock on or off.

The register port is synchronous with byte addresses. Only aligned offsets inside the window reach a register. Any access outside the window is dropped.

Top module: `audio_irq_ctl`

## Requirements
- R1: A one-cycle pulse on `ev[k]` sets a pending bit in the status register (offset 0x00) while the interrupt-logic reset is released. The bit positions are: port A out (`ev[0]`) at bit 0, port A in (`ev[1]`) at bit 4, port B out (`ev[2]`) at bit 8, port B in (`ev[3]`) at bit 12. The bit reads as 1 from the cycle after the pulse.
- R2: A pending bit stays set until software clears it or the interrupt-logic reset is applied.
- R3: A write to the status register clears every source position written as 0 and leaves every position written as 1 unchanged. It can never set a bit. If an event arrives in the same cycle as its clear, the bit stays set.
- R4: `irq` is high exactly when some status bit is set and the same bit is set in both enable registers.
- R5: The two enable registers (offsets 0x04 and 0x08) use the status bit layout and read back what was written at bits 0, 4, 8 and 12.
- R6: The software reset register (offset 0x14) drives these outputs directly from its stored bits: `glb_rst_n` from bit 0, `irq_rst_n` from bit 4, `porta_rst_n` from bit 8 and `portb_rst_n` from bit 12. It reads back its stored bits.
- R7: While reset register bit 4 holds 0, every status bit is cleared on the next clock and incoming events are ignored.
- R8: The clock enable register (offset 0x10) drives `clk_en_a` from bit 0 and `clk_en_b` from bit 4.
- R9: A read or write whose address lies below `WIN_BASE` or above `WIN_BASE`+0x14 changes no register, and its read returns 0. An unaligned or unmapped offset inside the window behaves the same way.
- R10: After hardware reset, every register holds zero. All four software resets are therefore asserted, both clocks are off and `irq` is low.
- R11: Register bits outside the defined positions read as 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe for the register port |
| rd_en | input | 1 | Read strobe; `rdata` is 0 when low |
| addr | input | AW | Byte address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data |
| ev | input | 4 | Event pulses: A out, A in, B out, B in |
| irq | output | 1 | Combined interrupt request |
| glb_rst_n | output | 1 | Global software reset, active low |
| irq_rst_n | output | 1 | Interrupt-logic reset, active low |
| porta_rst_n | output | 1 | Port A software reset, active low |
| portb_rst_n | output | 1 | Port B software reset, active low |
| clk_en_a | output | 1 | Port A clock enable |
| clk_en_b | output | 1 | Port B clock enable |

## Verification
The hardest case to reach from the ports is an event pulse that lands in the same cycle as a status write clearing that bit. A second hard case is a write that releases the interrupt-logic reset in the cycle an event arrives: the old reset value still holds, so that event is lost. The stimulus builds both collisions on purpose. A long random phase then drives events, status writes, reset-register writes and out-of-window addresses together. A behavioural model is compared on every clock and decides the outcome of each collision.

// File: rtl/audio_irq_ctl.sv
module audio_irq_ctl #(
  parameter int AW = 12,
  parameter logic [AW-1:0] WIN_BASE = 12'h180
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  input  logic [3:0]    ev,
  output logic          irq,
  output logic          glb_rst_n,
  output logic          irq_rst_n,
  output logic          porta_rst_n,
  output logic          portb_rst_n,
  output logic          clk_en_a,
  output logic          clk_en_b
);
  localparam logic [AW-1:0] OFS_STAT = AW'('h00);
  localparam logic [AW-1:0] OFS_EN0  = AW'('h04);
  localparam logic [AW-1:0] OFS_EN1  = AW'('h08);
  localparam logic [AW-1:0] OFS_CLK  = AW'('h10);
  localparam logic [AW-1:0] OFS_RST  = AW'('h14);
  localparam logic [AW-1:0] WIN_LAST = WIN_BASE + OFS_RST;
  localparam logic [15:0] SRC_MASK = 16'h1111;
  localparam logic [15:0] CLK_MASK = 16'h0011;

  logic [15:0] status_q, en0_q, en1_q, rst_q, clk_q;
  logic [15:0] ev_bits, keep;
  logic [AW-1:0] ofs;
  logic in_win;

  assign in_win  = (addr >= WIN_BASE) && (addr <= WIN_LAST);
  assign ofs     = addr - WIN_BASE;
  assign ev_bits = {3'b0, ev[3], 3'b0, ev[2], 3'b0, ev[1], 3'b0, ev[0]};
  assign keep    = (wr_en && in_win && ofs == OFS_STAT) ? wdata : 16'hFFFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      en0_q    <= '0;
      en1_q    <= '0;
      rst_q    <= '0;
      clk_q    <= '0;
    end else begin
      status_q <= rst_q[4] ? (((status_q & keep) | ev_bits) & SRC_MASK) : '0;
      if (wr_en && in_win) begin
        if (ofs == OFS_EN0) en0_q <= wdata & SRC_MASK;
        if (ofs == OFS_EN1) en1_q <= wdata & SRC_MASK;
        if (ofs == OFS_CLK) clk_q <= wdata & CLK_MASK;
        if (ofs == OFS_RST) rst_q <= wdata & SRC_MASK;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en && in_win) begin
      case (ofs)
        OFS_STAT: rdata = status_q;
        OFS_EN0:  rdata = en0_q;
        OFS_EN1:  rdata = en1_q;
        OFS_CLK:  rdata = clk_q;
        OFS_RST:  rdata = rst_q;
        default:  rdata = '0;
      endcase
    end
  end

  assign irq         = |(status_q & en0_q & en1_q);
  assign glb_rst_n   = rst_q[0];
  assign irq_rst_n   = rst_q[4];
  assign porta_rst_n = rst_q[8];
  assign portb_rst_n = rst_q[12];
  assign clk_en_a    = clk_q[0];
  assign clk_en_b    = clk_q[4];
endmodule

module audio_irq_ctl_chk #(
  parameter int AW = 12,
  parameter logic [AW-1:0] WIN_BASE = 12'h180
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [15:0]   rdata,
  input logic [3:0]    ev,
  input logic          irq,
  input logic          irq_rst_n,
  input logic          glb_rst_n,
  input logic          porta_rst_n,
  input logic          portb_rst_n,
  input logic          clk_en_a,
  input logic          clk_en_b,
  input logic [15:0]   status_q
);
  logic outside, stat_wr;
  assign outside = (addr < WIN_BASE) || (addr > WIN_BASE + AW'('h14));
  assign stat_wr = wr_en && (addr == WIN_BASE);

  for (genvar k = 0; k < 4; k++) begin : g_src
    a_r1_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rst_n && ev[k] |=> status_q[4*k]);
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rst_n && !stat_wr && status_q[4*k] |=> status_q[4*k]);
  end

  a_r7_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_rst_n |=> status_q == 16'h0);

  a_r4_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_rst_n && $past(!irq_rst_n) |-> !irq);

  a_r9_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && outside |-> rdata == 16'h0);

  a_r9_oob_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && outside |=> $stable({glb_rst_n, irq_rst_n, porta_rst_n, portb_rst_n, clk_en_a, clk_en_b}));
endmodule

bind audio_irq_ctl audio_irq_ctl_chk #(.AW(AW), .WIN_BASE(WIN_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .ev(ev), .irq(irq), .irq_rst_n(irq_rst_n),
  .glb_rst_n(glb_rst_n), .porta_rst_n(porta_rst_n), .portb_rst_n(portb_rst_n),
  .clk_en_a(clk_en_a), .clk_en_b(clk_en_b), .status_q(status_q)
);

// File: tb/audio_irq_ctl_test.sv
module audio_irq_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] BASE = 12'h180;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [3:0] ev = '0;
  logic [15:0] rdata;
  logic irq, glb_rst_n, irq_rst_n, porta_rst_n, portb_rst_n, clk_en_a, clk_en_b;

  int checks = 0, fails = 0;
  string tag = "R10";
  bit done = 0;

  int st = 0, m0 = 0, m1 = 0, rr = 0, ck = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_irq_ctl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ev(ev), .irq(irq), .glb_rst_n(glb_rst_n),
    .irq_rst_n(irq_rst_n), .porta_rst_n(porta_rst_n), .portb_rst_n(portb_rst_n),
    .clk_en_a(clk_en_a), .clk_en_b(clk_en_b)
  );

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int mread(input bit r, input logic [11:0] a);
    if (!r || a < BASE || a > BASE + 12'h14) return 0;
    case (int'(a - BASE))
      'h00: return st;
      'h04: return m0;
      'h08: return m1;
      'h10: return ck;
      'h14: return rr;
      default: return 0;
    endcase
  endfunction

  task automatic mupdate(input bit w, input logic [11:0] a, input logic [15:0] d, input logic [3:0] e);
    int evb, keep, nxt;
    bit hit;
    evb = 0;
    for (int k = 0; k < 4; k++) if (e[k]) evb |= (1 << (4*k));
    hit = w && a >= BASE && a <= BASE + 12'h14;
    keep = (hit && a == BASE) ? int'(d) : 'hFFFF;
    nxt = ((rr >> 4) & 1) ? (((st & keep) | evb) & 'h1111) : 0;
    st = nxt;
    if (hit) begin
      case (int'(a - BASE))
        'h04: m0 = d & 'h1111;
        'h08: m1 = d & 'h1111;
        'h10: ck = d & 'h0011;
        'h14: rr = d & 'h1111;
        default: ;
      endcase
    end
  endtask

  task automatic check_state();
    chk(int'(irq), int'((st & m0 & m1) != 0), "irq");
    chk(int'(glb_rst_n), rr & 1, "glb_rst_n");
    chk(int'(irq_rst_n), (rr >> 4) & 1, "irq_rst_n");
    chk(int'(porta_rst_n), (rr >> 8) & 1, "porta_rst_n");
    chk(int'(portb_rst_n), (rr >> 12) & 1, "portb_rst_n");
    chk(int'(clk_en_a), ck & 1, "clk_en_a");
    chk(int'(clk_en_b), (ck >> 4) & 1, "clk_en_b");
  endtask

  task automatic step(input bit w, input bit r, input logic [11:0] a, input logic [15:0] d, input logic [3:0] e);
    @(negedge clk);
    check_state();
    wr_en = w; rd_en = r; addr = a; wdata = d; ev = e;
    #1 chk(int'(rdata), mread(r, a), "rdata");
    @(posedge clk);
    mupdate(w, a, d, e);
  endtask

  task automatic wr(input int ofs, input logic [15:0] d);
    step(1, 0, BASE + 12'(ofs), d, 4'h0);
  endtask

  task automatic rd(input int ofs);
    step(0, 1, BASE + 12'(ofs), 16'h0, 4'h0);
  endtask

  task automatic pulse(input logic [3:0] e);
    step(0, 0, BASE, 16'h0, e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    tag = "R10";
    rd('h00); rd('h04); rd('h08); rd('h10); rd('h14);
    tag = "R7";
    pulse(4'hF); rd('h00);

    tag = "R6";
    wr('h14, 16'h1111); rd('h14);
    wr('h14, 16'h0101); rd('h14);
    wr('h14, 16'h1011); rd('h14);
    tag = "R11";
    wr('h14, 16'hFFFF); rd('h14);
    wr('h04, 16'hFFFF); rd('h04);
    tag = "R8";
    wr('h10, 16'h0011); rd('h10);
    wr('h10, 16'h0010); rd('h10);
    wr('h10, 16'h0001); rd('h10);

    tag = "R5";
    wr('h04, 16'h1111); wr('h08, 16'h1111); rd('h04); rd('h08);
    wr('h08, 16'h0110); rd('h08);

    tag = "R1";
    wr('h08, 16'h1111);
    for (int k = 0; k < 4; k++) begin
      pulse(4'(1 << k)); rd('h00);
    end
    tag = "R2";
    repeat (5) pulse(4'h0);
    rd('h00);

    tag = "R3";
    wr('h00, 16'hFFEF); rd('h00);
    wr('h00, 16'h0000); rd('h00);
    pulse(4'h4);
    step(1, 0, BASE, 16'h0000, 4'h4); rd('h00);
    pulse(4'h2);
    step(1, 0, BASE, 16'h0000, 4'h8); rd('h00);
    wr('h00, 16'h0000);

    tag = "R4";
    wr('h04, 16'h0101); wr('h08, 16'h0011);
    pulse(4'h2); rd('h00);
    pulse(4'h4); rd('h00);
    pulse(4'h1); rd('h00);
    wr('h00, 16'hFFFE); rd('h00);
    wr('h04, 16'h1111); wr('h08, 16'h1111);

    tag = "R7";
    pulse(4'hF);
    wr('h14, 16'h1101); rd('h00);
    pulse(4'hF); rd('h00);
    step(1, 0, BASE + 12'h14, 16'h1111, 4'h3); rd('h00);
    pulse(4'h8); rd('h00);

    tag = "R9";
    wr(-4, 16'h0000); wr('h18, 16'h0000); wr('h0C, 16'h0000); wr('h02, 16'h0000);
    step(1, 0, 12'h000, 16'h0000, 4'h0);
    rd(-4); rd('h18); rd('h0C); rd('h02); rd('h00);
    step(0, 1, 12'hFFF, 16'h0, 4'h0);

    tag = "R3";
    for (int i = 0; i < 600; i++) begin
      int pick;
      int offs [8] = '{'h00, 'h04, 'h08, 'h10, 'h14, 'h0C, -4, 'h18};
      pick = offs[$urandom_range(0, 7)];
      if (pick == 'h14 && $urandom_range(0, 3) != 0) pick = 'h00;
      step(1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 1)),
           BASE + 12'(pick), 16'($urandom_range(0, 16'hFFFF) | 16'h0010 * $urandom_range(0, 1)),
           4'($urandom_range(0, 15) & $urandom_range(0, 15)));
    end
    @(negedge clk);
    check_state();

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL %s watchdog actual=running expected=finished", tag);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule